// File: doc/BRIEF.md
# Power-on output enable sequencer

This block drives the output enables of a video decoder's pins from the moment power comes up until the device has been configured. While the asynchronous reset is held, every enable it controls is low, so all of those pins float. After reset is released, an internal reset phase runs for a programmable number of clock cycles. This phase stands for the 20 to 200 ms the device spends resetting itself.

Pins come out of high impedance in two stages. At the end of the internal reset phase, the pixel clock pin and the serial control data line are enabled. The 8-bit video output bus, the real-time control pin and the status pins stay floating. They are released only when a complete configuration write over the control bus has been reported after the reset phase. The write is reported as a one-cycle pulse. From then on the block stays in its final state until the next asynchronous reset, and later writes change nothing. The current phase is available on a 2-bit status output.

Top module: `pos_oe_seq`

## Requirements
- R1: While `arst_n` is low and in the first cycle after it rises, `state_o` is 0 (reset, all floating) and every enable output is 0.
- R2: `state_o` codes are: 0 reset, 1 internal reset in progress, 2 waiting for configuration, 3 running.
- R3: After the edge that leaves state 0, `state_o` reads 1 for exactly `RST_CYCLES` clock cycles, with every enable 0.
- R4: In state 2, `oe_pclk` and `oe_sdata` are 1, and `oe_vbus`, `oe_rtc` and `oe_stat` are all 0.
- R5: A `cfg_done` pulse while `state_o` is 0 or 1 is ignored: the state sequence and its timing do not change.
- R6: A `cfg_done` pulse sampled in state 2 moves the block to state 3 on that edge, and in state 3 every enable output is 1.
- R7: State 3 is kept whatever `cfg_done` does, until `arst_n` goes low.
- R8: Pulling `arst_n` low in any state sets `state_o` to 0 and every enable to 0 at once, without waiting for a clock edge.
- R9: All bits of `oe_vbus` are equal, and all bits of `oe_stat` are equal, in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| cfg_done | input | 1 | One-cycle pulse marking the end of a complete control-bus write |
| oe_pclk | output | 1 | Pixel clock pin enable |
| oe_sdata | output | 1 | Serial control data line enable |
| oe_vbus | output | VB_W | Per-bit enables of the video output bus |
| oe_rtc | output | 1 | Real-time control pin enable |
| oe_stat | output | ST_W | Per-pin enables of the status outputs |
| state_o | output | 2 | Current phase code |

## Verification
The assertions check every cycle that no pin is driven during the reset phases, that the data and status enables never come on without the clock and serial line enables, that the running state is sticky, and that the bus and status enables stay uniform. They also count the internal reset phase and check that it ends exactly at its limit. Only the bench scenarios can show how each phase is timed relative to reset release. They also show that pulses landing in the reset phases, including one on the very last reset cycle, are really ignored, and that an asynchronous reset in the middle of a run clears everything before the next clock edge.

// File: rtl/pos_pkg.sv
package pos_pkg;
    typedef enum logic [1:0] {
        ST_RESET_HIZ   = 2'd0,
        ST_INT_RESET   = 2'd1,
        ST_WAIT_CONFIG = 2'd2,
        ST_RUN         = 2'd3
    } pos_state_e;
endpackage

// File: rtl/pos_delay_cnt.sv
// Counts the cycles of the internal reset phase while run is high.
module pos_delay_cnt #(
    parameter int CYCLES = 1_000_000,
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run,
    output logic expired
);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d.cnt = '0;
        end else if (cnt_q.cnt != LAST) begin
            cnt_d.cnt = cnt_q.cnt + CW'(1);
        end
        expired = run && (cnt_q.cnt == LAST);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pos_fsm.sv
// Phase sequencer: reset -> internal reset -> wait for config -> run.
module pos_fsm
    import pos_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       delay_done,
    input  logic       cfg_done,
    output pos_state_e state
);
    typedef struct packed {
        pos_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_RESET_HIZ:   fsm_d.st = ST_INT_RESET;
            ST_INT_RESET:   if (delay_done) fsm_d.st = ST_WAIT_CONFIG;
            ST_WAIT_CONFIG: if (cfg_done) fsm_d.st = ST_RUN;
            ST_RUN:         fsm_d.st = ST_RUN;
            default:        fsm_d.st = ST_RESET_HIZ;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            fsm_q.st <= ST_RESET_HIZ;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state = fsm_q.st;
endmodule

// File: rtl/pos_oe_decode.sv
// Maps the phase to the per-pin enables. The reset forces all enables low
// directly, so pins float even before any clock edge.
module pos_oe_decode
    import pos_pkg::*;
#(
    parameter int VB_W = 8,
    parameter int ST_W = 2
) (
    input  logic            arst_n,
    input  pos_state_e      state,
    output logic            oe_pclk,
    output logic            oe_sdata,
    output logic [VB_W-1:0] oe_vbus,
    output logic            oe_rtc,
    output logic [ST_W-1:0] oe_stat
);
    logic stage1_en;
    logic stage2_en;

    always_comb begin
        stage1_en = arst_n && ((state == ST_WAIT_CONFIG) || (state == ST_RUN));
        stage2_en = arst_n && (state == ST_RUN);
    end

    assign oe_pclk  = stage1_en;
    assign oe_sdata = stage1_en;
    assign oe_rtc   = stage2_en;

    for (genvar b = 0; b < VB_W; b++) begin : g_vbus
        assign oe_vbus[b] = stage2_en;
    end

    for (genvar s = 0; s < ST_W; s++) begin : g_stat
        assign oe_stat[s] = stage2_en;
    end
endmodule

// File: rtl/pos_oe_seq.sv
module pos_oe_seq
    import pos_pkg::*;
#(
    parameter int RST_CYCLES = 1_000_000,
    parameter int VB_W       = 8,
    parameter int ST_W       = 2
) (
    input  logic            clk,
    input  logic            arst_n,
    input  logic            cfg_done,
    output logic            oe_pclk,
    output logic            oe_sdata,
    output logic [VB_W-1:0] oe_vbus,
    output logic            oe_rtc,
    output logic [ST_W-1:0] oe_stat,
    output logic [1:0]      state_o
);
    pos_state_e state;
    logic       delay_run;
    logic       delay_done;

    assign delay_run = (state == ST_INT_RESET);

    pos_delay_cnt #(.CYCLES(RST_CYCLES)) delay_i (
        .clk     (clk),
        .arst_n  (arst_n),
        .run     (delay_run),
        .expired (delay_done)
    );

    pos_fsm fsm_i (
        .clk        (clk),
        .arst_n     (arst_n),
        .delay_done (delay_done),
        .cfg_done   (cfg_done),
        .state      (state)
    );

    pos_oe_decode #(.VB_W(VB_W), .ST_W(ST_W)) dec_i (
        .arst_n   (arst_n),
        .state    (state),
        .oe_pclk  (oe_pclk),
        .oe_sdata (oe_sdata),
        .oe_vbus  (oe_vbus),
        .oe_rtc   (oe_rtc),
        .oe_stat  (oe_stat)
    );

    assign state_o = state;
endmodule

// File: rtl/pos_oe_seq_chk.sv
module pos_oe_seq_chk #(
    parameter int RST_CYCLES = 1_000_000,
    parameter int VB_W       = 8,
    parameter int ST_W       = 2
) (
    input logic            clk,
    input logic            arst_n,
    input logic            cfg_done,
    input logic            oe_pclk,
    input logic            oe_sdata,
    input logic [VB_W-1:0] oe_vbus,
    input logic            oe_rtc,
    input logic [ST_W-1:0] oe_stat,
    input logic [1:0]      state_o
);
    localparam logic [31:0] INT_LAST = 32'(RST_CYCLES - 1);

    logic [31:0] int_len;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            int_len <= '0;
        end else if (state_o == 2'd1) begin
            int_len <= int_len + 32'd1;
        end else begin
            int_len <= '0;
        end
    end

    AST_NO_EARLY_DRIVE: assert property (@(posedge clk) disable iff (!arst_n)
        (state_o == 2'd0 || state_o == 2'd1) |->
        !(oe_pclk || oe_sdata || oe_rtc || (|oe_vbus) || (|oe_stat))); // R1
    AST_INT_LEN_MAX: assert property (@(posedge clk) disable iff (!arst_n)
        (state_o == 2'd1) |-> (int_len <= INT_LAST)); // R3
    AST_INT_LEN_EXACT: assert property (@(posedge clk) disable iff (!arst_n)
        (state_o == 2'd1 && int_len == INT_LAST) |=> (state_o == 2'd2)); // R3
    AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (!arst_n)
        (oe_rtc || (|oe_vbus) || (|oe_stat)) |-> (oe_pclk && oe_sdata)); // R4
    AST_NO_SKIP: assert property (@(posedge clk) disable iff (!arst_n)
        (state_o == 2'd1) |=> (state_o != 2'd3)); // R5
    AST_CFG_ADVANCE: assert property (@(posedge clk) disable iff (!arst_n)
        (state_o == 2'd2 && cfg_done) |=> (state_o == 2'd3)); // R6
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!arst_n)
        (state_o == 2'd3) |=> (state_o == 2'd3)); // R7
    AST_BUS_UNIFORM: assert property (@(posedge clk) disable iff (!arst_n)
        (oe_vbus == {VB_W{oe_pclk && oe_rtc}}) && (oe_stat == {ST_W{oe_rtc}})); // R9
endmodule

bind pos_oe_seq pos_oe_seq_chk #(
    .RST_CYCLES (RST_CYCLES),
    .VB_W       (VB_W),
    .ST_W       (ST_W)
) chk_i (
    .clk      (clk),
    .arst_n   (arst_n),
    .cfg_done (cfg_done),
    .oe_pclk  (oe_pclk),
    .oe_sdata (oe_sdata),
    .oe_vbus  (oe_vbus),
    .oe_rtc   (oe_rtc),
    .oe_stat  (oe_stat),
    .state_o  (state_o)
);

// File: tb/pos_oe_seq_tb_top.sv
`timescale 1ns/1ps
module pos_oe_seq_tb_top;
    localparam int N    = 12;
    localparam int VB_W = 8;
    localparam int ST_W = 2;
    localparam int OW   = 3 + VB_W + ST_W;

    logic            clk = 1'b0;
    logic            arst_n = 1'b0;
    logic            cfg_done = 1'b0;
    logic            oe_pclk, oe_sdata, oe_rtc;
    logic [VB_W-1:0] oe_vbus;
    logic [ST_W-1:0] oe_stat;
    logic [1:0]      state_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pos_oe_seq #(.RST_CYCLES(N), .VB_W(VB_W), .ST_W(ST_W)) dut_i (
        .clk(clk), .arst_n(arst_n), .cfg_done(cfg_done),
        .oe_pclk(oe_pclk), .oe_sdata(oe_sdata), .oe_vbus(oe_vbus),
        .oe_rtc(oe_rtc), .oe_stat(oe_stat), .state_o(state_o)
    );

    // Expected enables from the phase code (R2, R4, R6).
    function automatic logic [OW-1:0] exp_oe(input logic [1:0] st);
        logic s1, s2;
        s1 = (st == 2'd2) || (st == 2'd3);
        s2 = (st == 2'd3);
        return {s1, s1, {VB_W{s2}}, s2, {ST_W{s2}}};
    endfunction

    function automatic logic [OW-1:0] act_oe();
        return {oe_pclk, oe_sdata, oe_vbus, oe_rtc, oe_stat};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_phase(input string req, input logic [1:0] st);
        chk({req, " state"}, 32'(state_o), 32'(st));
        chk({req, " enables"}, 32'(act_oe()), 32'(exp_oe(st)));
    endtask

    // One full power-on sequence with random reset timing and pulse positions.
    task automatic run_round(input bool_mid_abort);
        int wait_cfg;
        int run_len;
        @(negedge clk);
        #3 arst_n = 1'b0;
        #1 chk_phase("R8", 2'd0);
        cfg_done = 1'b1; // R5: pulse during reset
        repeat (1 + $urandom_range(3)) @(negedge clk);
        chk_phase("R1", 2'd0);
        arst_n = 1'b1;
        cfg_done = 1'($urandom_range(1));
        // First edge after release leaves state 0.
        for (int i = 1; i <= N; i++) begin
            @(negedge clk);
            chk_phase("R3", 2'd1);
            // R5: random pulses, forced on the final internal reset cycle
            cfg_done = (i == N) ? 1'b1 : 1'($urandom_range(1));
        end
        @(negedge clk);
        chk_phase("R4", 2'd2);
        cfg_done = 1'b0;
        if (bool_mid_abort) begin
            #5 arst_n = 1'b0;
            #1 chk_phase("R8", 2'd0);
            return;
        end
        wait_cfg = $urandom_range(5);
        for (int w = 0; w < wait_cfg; w++) begin
            @(negedge clk);
            chk_phase("R4", 2'd2);
        end
        cfg_done = 1'b1;
        @(negedge clk);
        chk_phase("R6", 2'd3);
        cfg_done = 1'b0;
        run_len = 3 + $urandom_range(6);
        for (int r = 0; r < run_len; r++) begin
            cfg_done = 1'($urandom_range(1));
            @(negedge clk);
            chk_phase("R7", 2'd3);
            chk("R9 vbus", 32'(oe_vbus), 32'({VB_W{1'b1}}));
        end
        cfg_done = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        #1 chk_phase("R1", 2'd0);
        repeat (2) @(negedge clk);
        chk_phase("R1", 2'd0);
        // Directed: release and verify first-cycle timing exactly.
        arst_n = 1'b1;
        #1 chk_phase("R1", 2'd0);
        for (int k = 0; k < 12; k++) begin
            run_round(k == 3 || k == 7);
        end
        // Directed: reset asserted in the middle of RUN.
        run_round(1'b0);
        #5 arst_n = 1'b0;
        #1 chk_phase("R8", 2'd0);
        chk("R9 stat", 32'(oe_stat), 32'(0));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule